// File: doc/BRIEF.md
# Trace and Privilege Exception Sequencer

This block sits beside the execution unit of a two-mode (user and supervisor) processor core. It decides which exceptions an instruction raises, and in what order. It also owns the status word that carries the supervisor (S) and trace (T) bits.

When an instruction begins, the block checks three conditions:
- whether an interrupt preempts the instruction;
- whether the opcode is illegal;
- whether a supervisor-only instruction is being attempted in user mode.

If any of these holds, the instruction is squashed and a single exception is queued. Otherwise the instruction runs. At its boundary the block queues, in this order:
1. the instruction's own trap;
2. a trace exception, if T was set when the instruction began;
3. any pending interrupt.

An abort discards everything that was queued.

Each queued exception is presented for one cycle. The presentation carries the vector number, the program counter to stack and the status word to stack. The next exception is presented only after the stacking and vector-fetch logic acknowledges the current one. Presenting an exception enters supervisor mode and turns tracing off. The stacked status word is always the value held before that change.

Top module: `trace_priv_seq`

## Requirements
- R1: An instruction flagged supervisor-only that starts while S (status bit 13) is 0 is squashed. It raises vector 8, and the stacked PC is the instruction's own start address.
- R2: The status word stacked with an exception is the value before the exception. From the cycle after the request, S (bit 13) reads 1 and T (bit 15) reads 0, and all other status bits are kept.
- R3: An illegal opcode is squashed and raises vector 4 with the start address stacked. It takes precedence over the supervisor-only check, and no trace follows it.
- R4: T is sampled when the instruction starts. Trace (vector 9, stacking the next-instruction address) follows completion if T was 1 at start, even when the instruction clears T. No trace follows if T was 0 at start, even when the instruction sets T.
- R5: An interrupt pending at instruction start squashes the instruction. Its vector is taken from the interrupt vector input, the start address is stacked, and no trace follows.
- R6: An abort while an instruction executes discards its trap, trace and interrupt, so no exception request follows.
- R7: At completion the exceptions are presented in the order trap (vector from its input), then trace, then interrupt. Each of them stacks the next-instruction address.
- R8: Each exception request is high for exactly one cycle. No further request appears until the current one is acknowledged.
- R9: Reset discards all queued exceptions, drops any request, and sets the status word to S=1 with every other bit 0.
- R10: The second and later exceptions of one boundary sequence stack the status word with S=1 and T=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_start | input | 1 | Instruction begins this cycle |
| insn_pc | input | 32 | Address of the starting instruction |
| insn_priv | input | 1 | Decoder: instruction is supervisor-only |
| insn_illegal | input | 1 | Decoder: opcode is illegal |
| insn_done | input | 1 | Instruction completes this cycle |
| insn_trap | input | 1 | Completing instruction forces a trap |
| trap_vec | input | 8 | Vector of the forced trap |
| insn_abort | input | 1 | Instruction aborted (reset, bus or address error) |
| next_pc | input | 32 | Address of the following instruction, valid with completion |
| irq_pend | input | 1 | An interrupt is pending |
| irq_vec | input | 8 | Vector of the pending interrupt |
| sr_wr | input | 1 | Instruction writes the status word |
| sr_wdata | input | 16 | Status word to write |
| exc_ack | input | 1 | Current exception has been stacked and vectored |
| insn_squash | output | 1 | Starting instruction must not execute |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | 8 | Vector number of the request |
| exc_pc | output | 32 | PC to stack |
| exc_sr | output | 16 | Status word to stack |
| sr_out | output | 16 | Current status word |

## Verification
The assertions assume that the core honours the sequencer's handshake:
- a start arrives only while the sequencer is idle;
- completion or abort arrives only for an instruction that is running;
- an acknowledge is given only after a request has been seen;
- status writes happen only outside an exception sequence.

The bench drives every instruction through the same start, execute, complete and acknowledge routine. It holds off each acknowledge for two cycles, and it presents a start only after the previous sequence has drained. As a result, the stimulus never leaves those conditions except through the deliberate reset applied in the middle of a sequence.

// File: rtl/tpx_pkg.sv
package tpx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_ISSUE, ST_WAIT} seq_state_e;

  // queue slots, lowest index presented first
  localparam int NSLOT      = 4;
  localparam int SLOT_FAULT = 0;
  localparam int SLOT_TRAP  = 1;
  localparam int SLOT_TRACE = 2;
  localparam int SLOT_IRQ   = 3;

  localparam int VEC_ILLEGAL = 4;
  localparam int VEC_PRIV    = 8;
  localparam int VEC_TRACE   = 9;
endpackage

// File: rtl/tpx_prio_pick.sv
module tpx_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant[i]   = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/tpx_status_reg.sv
module tpx_status_reg #(
  parameter int SRW   = 16,
  parameter int S_BIT = 13,
  parameter int T_BIT = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [SRW-1:0] wr_data,
  input  logic           enter_exc,
  output logic [SRW-1:0] sr_q
);
  localparam logic [SRW-1:0] SR_RESET = SRW'(1) << S_BIT;

  logic [SRW-1:0] sr_d;
  logic           sr_en;

  always_comb begin
    sr_en = enter_exc | wr_en;
    sr_d  = sr_q;
    if (enter_exc) begin
      sr_d[S_BIT] = 1'b1;
      sr_d[T_BIT] = 1'b0;
    end else if (wr_en) begin
      sr_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= SR_RESET;
    else if (sr_en) sr_q <= sr_d;
  end

  // R2: entering an exception leaves supervisor mode on and tracing off
  assert_enter_sup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_exc |=> (sr_q[S_BIT] && !sr_q[T_BIT]));

  // R2: other status bits survive the mode change
  assert_keep_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_exc |=> ((sr_q | (SRW'(1) << S_BIT) | (SRW'(1) << T_BIT)) ==
                   ($past(sr_q) | (SRW'(1) << S_BIT) | (SRW'(1) << T_BIT))));
endmodule

// File: rtl/trace_priv_seq.sv
module trace_priv_seq
  import tpx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int VW    = 8,
  parameter int SRW   = 16,
  parameter int S_BIT = 13,
  parameter int T_BIT = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           insn_start,
  input  logic [AW-1:0]  insn_pc,
  input  logic           insn_priv,
  input  logic           insn_illegal,
  input  logic           insn_done,
  input  logic           insn_trap,
  input  logic [VW-1:0]  trap_vec,
  input  logic           insn_abort,
  input  logic [AW-1:0]  next_pc,
  input  logic           irq_pend,
  input  logic [VW-1:0]  irq_vec,
  input  logic           sr_wr,
  input  logic [SRW-1:0] sr_wdata,
  input  logic           exc_ack,
  output logic           insn_squash,
  output logic           exc_req,
  output logic [VW-1:0]  exc_vec,
  output logic [AW-1:0]  exc_pc,
  output logic [SRW-1:0] exc_sr,
  output logic [SRW-1:0] sr_out
);
  localparam logic [VW-1:0] V_ILL   = VW'(VEC_ILLEGAL);
  localparam logic [VW-1:0] V_PRIV  = VW'(VEC_PRIV);
  localparam logic [VW-1:0] V_TRACE = VW'(VEC_TRACE);

  seq_state_e       state_q, state_d;
  logic [NSLOT-1:0] pend_q, pend_d, grant, pend_left;
  logic [VW-1:0]    fvec_q, fvec_d, tvec_q, ivec_q;
  logic [AW-1:0]    fpc_q, npc_q;
  logic             tsamp_q;
  logic [SRW-1:0]   sr_q;
  logic             start_ok, user_mode, ld_start, ld_done, pend_en, issuing;

  tpx_prio_pick #(.N(NSLOT)) u_pick (.req(pend_q), .grant(grant));

  tpx_status_reg #(.SRW(SRW), .S_BIT(S_BIT), .T_BIT(T_BIT)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sr_wr & ((state_q == ST_IDLE) | (state_q == ST_EXEC))),
    .wr_data  (sr_wdata),
    .enter_exc(issuing),
    .sr_q     (sr_q)
  );

  assign user_mode   = ~sr_q[S_BIT];
  assign start_ok    = (state_q == ST_IDLE) & insn_start;
  assign insn_squash = start_ok & (irq_pend | insn_illegal | (insn_priv & user_mode));
  assign issuing     = (state_q == ST_ISSUE);
  assign pend_left   = pend_q & ~grant;
  assign ld_start    = start_ok;
  assign ld_done     = (state_q == ST_EXEC) & insn_done & ~insn_abort;

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    pend_en = 1'b0;
    fvec_d  = fvec_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          if (insn_squash) begin
            pend_d  = NSLOT'(1) << SLOT_FAULT;
            pend_en = 1'b1;
            if (irq_pend)          fvec_d = irq_vec;
            else if (insn_illegal) fvec_d = V_ILL;
            else                   fvec_d = V_PRIV;
            state_d = ST_ISSUE;
          end else begin
            state_d = ST_EXEC;
          end
        end
      end
      ST_EXEC: begin
        if (insn_abort) begin
          pend_d  = '0;
          pend_en = 1'b1;
          state_d = ST_IDLE;
        end else if (insn_done) begin
          pend_d = '0;
          pend_d[SLOT_TRAP]  = insn_trap;
          pend_d[SLOT_TRACE] = tsamp_q;
          pend_d[SLOT_IRQ]   = irq_pend;
          pend_en = 1'b1;
          state_d = (insn_trap | tsamp_q | irq_pend) ? ST_ISSUE : ST_IDLE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (exc_ack) begin
          pend_d  = pend_left;
          pend_en = 1'b1;
          state_d = (pend_left != '0) ? ST_ISSUE : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fvec_q  <= '0;
      fpc_q   <= '0;
      tsamp_q <= 1'b0;
    end else if (ld_start) begin
      fvec_q  <= fvec_d;
      fpc_q   <= insn_pc;
      tsamp_q <= sr_q[T_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvec_q <= '0;
      ivec_q <= '0;
      npc_q  <= '0;
    end else if (ld_done) begin
      tvec_q <= trap_vec;
      ivec_q <= irq_vec;
      npc_q  <= next_pc;
    end
  end

  // request outputs
  always_comb begin
    exc_vec = ivec_q;
    if (grant[SLOT_FAULT])      exc_vec = fvec_q;
    else if (grant[SLOT_TRAP])  exc_vec = tvec_q;
    else if (grant[SLOT_TRACE]) exc_vec = V_TRACE;
  end

  assign exc_req = issuing;
  assign exc_pc  = grant[SLOT_FAULT] ? fpc_q : npc_q;
  assign exc_sr  = sr_q;
  assign sr_out  = sr_q;

  // assertions
  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !exc_req);

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && !exc_ack) |=> !exc_req);

  assert_priv_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && insn_priv && user_mode && !irq_pend && !insn_illegal)
      |=> (exc_req && exc_vec == V_PRIV && exc_pc == $past(insn_pc)));

  assert_abort_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EXEC) && insn_abort) |=> (state_q == ST_IDLE && pend_q == '0));

  assert_trace_queued_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EXEC) && insn_done && !insn_abort && tsamp_q) |=> pend_q[SLOT_TRACE]);

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $onehot(grant));
endmodule

// File: tb/trace_priv_seq_tb_top.sv
`timescale 1ns/1ps
module trace_priv_seq_tb_top;
  localparam logic [7:0]  TRAPV = 8'd33;
  localparam logic [7:0]  IRQV  = 8'd26;
  localparam logic [15:0] S_M   = 16'h2000;
  localparam logic [15:0] T_M   = 16'h8000;

  typedef struct packed {
    logic [15:0] sr0;
    logic        priv, ill, irq0, wr_en;
    logic [15:0] wr_val;
    logic        trap, irqd, abort;
    logic [1:0]  n;
    logic [7:0]  v0, v1, v2;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TABLE [NV] = '{
    '{16'h8405, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 8'd8,  8'd0, 8'd0},
    '{16'hA405, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 8'd9,  8'd0, 8'd0},
    '{16'h8405, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 8'd4,  8'd0, 8'd0},
    '{16'h8405, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, IRQV,  8'd0, 8'd0},
    '{16'h8405, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0405, 1'b0, 1'b0, 1'b0, 2'd1, 8'd9,  8'd0, 8'd0},
    '{16'h0405, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8405, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0, 8'd0},
    '{16'h8405, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3, TRAPV, 8'd9, IRQV},
    '{16'h8405, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd0, 8'd0,  8'd0, 8'd0},
    '{16'h0405, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2, TRAPV, IRQV, 8'd0},
    '{16'hA405, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd2, 8'd9,  IRQV, 8'd0},
    '{16'h0405, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 8'd4,  8'd0, 8'd0},
    '{16'h2405, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_start, insn_priv, insn_illegal, insn_done, insn_trap, insn_abort;
  logic        irq_pend, sr_wr, exc_ack;
  logic [31:0] insn_pc, next_pc;
  logic [7:0]  trap_vec, irq_vec;
  logic [15:0] sr_wdata;
  logic        insn_squash, exc_req;
  logic [7:0]  exc_vec;
  logic [31:0] exc_pc;
  logic [15:0] exc_sr, sr_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trace_priv_seq dut_i (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_pc(insn_pc),
    .insn_priv(insn_priv), .insn_illegal(insn_illegal), .insn_done(insn_done),
    .insn_trap(insn_trap), .trap_vec(trap_vec), .insn_abort(insn_abort),
    .next_pc(next_pc), .irq_pend(irq_pend), .irq_vec(irq_vec), .sr_wr(sr_wr),
    .sr_wdata(sr_wdata), .exc_ack(exc_ack), .insn_squash(insn_squash),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_pc(exc_pc), .exc_sr(exc_sr),
    .sr_out(sr_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_sr(input logic [15:0] v);
    sr_wr = 1'b1; sr_wdata = v;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  // collect up to 4 requests, acknowledging each after a 2-cycle hold
  task automatic collect(output int cnt, output logic [7:0] vs [4],
                         output logic [31:0] pcs [4], output logic [15:0] srs [4]);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      int w = 0;
      while (!exc_req && w < 3) begin
        @(negedge clk); w++;
      end
      if (!exc_req) break;
      vs[cnt] = exc_vec; pcs[cnt] = exc_pc; srs[cnt] = exc_sr;
      cnt++;
      @(negedge clk);
      chk("R8 request one cycle", 32'(exc_req), 32'd0);
      @(negedge clk);
      chk("R8 no request before ack", 32'(exc_req), 32'd0);
      exc_ack = 1'b1;
      @(negedge clk);
      exc_ack = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hang expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    insn_start = 0; insn_priv = 0; insn_illegal = 0; insn_done = 0; insn_trap = 0;
    insn_abort = 0; irq_pend = 0; sr_wr = 0; exc_ack = 0;
    insn_pc = '0; next_pc = '0; trap_vec = TRAPV; irq_vec = IRQV; sr_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset status word", 32'(sr_out), 32'(S_M));
    chk("R9 no request in reset", 32'(exc_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 no request after release", 32'(exc_req), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t e = TABLE[i];
      logic sq;
      logic [15:0] sr_pre;
      logic [31:0] spc, npc;
      int cnt;
      logic [7:0]  vs [4];
      logic [31:0] pcs [4];
      logic [15:0] srs [4];
      logic [7:0]  ev [3];
      spc = 32'h1000 + 32'(i) * 32'h40;
      npc = spc + 32'd4;
      sq  = e.irq0 | e.ill | (e.priv & ~e.sr0[13]);
      ev[0] = e.v0; ev[1] = e.v1; ev[2] = e.v2;
      set_sr(e.sr0);
      insn_start = 1'b1; insn_pc = spc; insn_priv = e.priv;
      insn_illegal = e.ill; irq_pend = e.irq0;
      #1;
      chk($sformatf("R1 R3 R5 squash entry %0d", i), 32'(insn_squash), 32'(sq));
      @(negedge clk);
      insn_start = 0; insn_priv = 0; insn_illegal = 0; irq_pend = 0;
      sr_pre = e.sr0;
      if (!sq) begin
        if (e.wr_en) begin
          set_sr(e.wr_val);
          sr_pre = e.wr_val;
        end
        next_pc = npc;
        if (e.abort) begin
          insn_abort = 1'b1; irq_pend = e.irqd;
        end else begin
          insn_done = 1'b1; insn_trap = e.trap; irq_pend = e.irqd;
        end
        @(negedge clk);
        insn_abort = 0; insn_done = 0; insn_trap = 0; irq_pend = 0;
      end
      collect(cnt, vs, pcs, srs);
      // R4 R6 R7: number and order of exceptions
      chk($sformatf("R4 R6 R7 count entry %0d", i), 32'(cnt), 32'(e.n));
      for (int k = 0; k < 3; k++) begin
        if (k < int'(e.n) && k < cnt) begin
          chk($sformatf("R7 vector entry %0d slot %0d", i, k), 32'(vs[k]), 32'(ev[k]));
          chk($sformatf("R1 R7 stacked pc entry %0d slot %0d", i, k), pcs[k],
              (k == 0 && sq) ? spc : npc);
          chk($sformatf("R2 R10 stacked sr entry %0d slot %0d", i, k), 32'(srs[k]),
              (k == 0) ? 32'(sr_pre) : 32'((sr_pre | S_M) & ~T_M));
        end
      end
      if (cnt > 0)
        chk($sformatf("R2 status after entry %0d", i), 32'(sr_out), 32'((sr_pre | S_M) & ~T_M));
    end

    // R9: reset in the middle of a sequence drops the queue
    set_sr(16'h8405);
    insn_start = 1'b1; insn_pc = 32'h2000;
    @(negedge clk);
    insn_start = 0;
    insn_done = 1'b1; insn_trap = 1'b1; irq_pend = 1'b1; next_pc = 32'h2004;
    @(negedge clk);
    insn_done = 0; insn_trap = 0; irq_pend = 0;
    chk("R8 first request of sequence", 32'(exc_req), 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 request low in reset", 32'(exc_req), 32'd0);
    chk("R9 status reset mid-sequence", 32'(sr_out), 32'(S_M));
    @(negedge clk);
    rst_n = 1'b1;
    exc_ack = 1'b1;
    @(negedge clk);
    exc_ack = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 queue discarded", 32'(exc_req), 32'd0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule